// File: doc/BRIEF.md
# Serial Configuration Loader for a Two-Channel Synthesizer

This block is the configuration front end of a two-channel frequency synthesizer. A host drives three slow wires (a serial clock, a serial data line and a load strobe). The block resynchronizes all three into the system clock domain and shifts one data bit into a 23-bit word on each detected rising edge of the serial clock, most significant bit first. When the load strobe goes high, the two lowest bits of the word pick one of four destination register sets. These are the reference divider of channel 1 or channel 2, or the main/swallow divider of channel 1 or channel 2. The word is then copied into that set.

Reference frames and divider frames place different fields in the same 23 bits. A frame whose divide value is below the legal floor is thrown away and a sticky error flag is raised. The latched fields are driven straight out to the divider datapaths.

Control is a three-state machine. ST_SHIFT accepts serial bits while the strobe is low. On a high strobe it moves to ST_COMMIT, which lasts one cycle and writes the selected set if the frame is legal. It then always moves to ST_HOLD, which ignores the serial clock until the strobe falls and then returns to ST_SHIFT.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset every reference ratio reads 3, every main count reads 3, every swallow count reads 0, and every flag bit and `frame_err` read 0.
- R2: While `ser_le` is low, each rising edge of `ser_clk` shifts `ser_data` into a 23-bit word, most significant bit first. The last bit sent becomes bit 0.
- R3: On load, word bits {1,0} select the destination: 00 is channel 1 reference, 01 is channel 2 reference, 10 is channel 1 divider, 11 is channel 2 divider.
- R4: In a reference frame, bit 2 is test-select bit 0 and bit 3 is test-select bit 1. Bits 17:4 hold the 14-bit ratio and bit 18 is the charge-pump current select. Bits 22:19 are ignored.
- R5: In a divider frame, bit 2 is the monitor select, bit 3 the prescaler select and bit 4 the phase polarity. Bits 11:5 hold the 7-bit swallow count and bits 22:12 the 11-bit main count.
- R6: A load changes only the selected register set; the other three keep their values.
- R7: Rising edges of `ser_clk` while `ser_le` is high shift nothing.
- R8: A reference frame with ratio below 3, or a divider frame with main count below 3, changes no register and sets `frame_err`.
- R9: The extremes are accepted: ratio 3 and 16383, main count 3 and 2047, swallow count 0 and 127.
- R10: `frame_err` stays set until reset, including across later legal loads.
- R11: A load becomes visible at the fourth system clock rising edge after `ser_le` rises, and not at the third. One strobe pulse commits once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_le | input | 1 | Load strobe (asynchronous) |
| ref_ratio_ch1 | output | 14 | Channel 1 reference ratio |
| ref_tsel_ch1 | output | 2 | Channel 1 test-select bits |
| cp_hi_ch1 | output | 1 | Channel 1 charge-pump high current |
| main_count_ch1 | output | 11 | Channel 1 main count |
| swallow_ch1 | output | 7 | Channel 1 swallow count |
| presc_sel_ch1 | output | 1 | Channel 1 prescaler modulus select |
| phase_pol_ch1 | output | 1 | Channel 1 phase polarity |
| mon_sel_ch1 | output | 1 | Channel 1 monitor output select |
| ref_ratio_ch2 | output | 14 | Channel 2 reference ratio |
| ref_tsel_ch2 | output | 2 | Channel 2 test-select bits |
| cp_hi_ch2 | output | 1 | Channel 2 charge-pump high current |
| main_count_ch2 | output | 11 | Channel 2 main count |
| swallow_ch2 | output | 7 | Channel 2 swallow count |
| presc_sel_ch2 | output | 1 | Channel 2 prescaler modulus select |
| phase_pol_ch2 | output | 1 | Channel 2 phase polarity |
| mon_sel_ch2 | output | 1 | Channel 2 monitor output select |
| frame_err | output | 1 | Sticky illegal-frame flag |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a floor of 3 for both the reference ratio and the main count. With two stages, the load latency is exactly four system edges, so the bench can tell a commit that lands one cycle early from one on time. With a floor of 3, the rejected values 0 and 2 and the accepted boundary 3 can be sent in one short frame table, together with the full-scale ratio, main and swallow values.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;

    localparam int FRAME_W  = 23;
    localparam int REF_W    = 14;
    localparam int MAIN_W   = 11;
    localparam int SWAL_W   = 7;
    localparam int TSEL_W   = 2;
    localparam int NUM_CH   = 2;

    // field positions inside the 23-bit frame
    localparam int TSEL_LSB = 2;
    localparam int REF_LSB  = TSEL_LSB + TSEL_W;
    localparam int CS_POS   = REF_LSB + REF_W;
    localparam int LDS_POS  = 2;
    localparam int SWAL_LSB = LDS_POS + 3;
    localparam int MAIN_LSB = SWAL_LSB + SWAL_W;

    localparam int REF_BUNDLE_W  = 1 + REF_W + TSEL_W;
    localparam int MAIN_BUNDLE_W = MAIN_W + SWAL_W + 3;

    typedef enum logic [1:0] {
        DST_REF1  = 2'b00,
        DST_REF2  = 2'b01,
        DST_MAIN1 = 2'b10,
        DST_MAIN2 = 2'b11
    } dest_e;

    typedef struct packed {
        logic              cp_hi;
        logic [REF_W-1:0]  ratio;
        logic [TSEL_W-1:0] tsel;
    } ref_regs_t;

    typedef struct packed {
        logic [MAIN_W-1:0] count;
        logic [SWAL_W-1:0] swallow;
        logic              pol;
        logic              presc;
        logic              mon;
    } main_regs_t;

    typedef enum logic [1:0] {
        ST_SHIFT  = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } ld_state_e;

endpackage

// File: rtl/synth_cfg_sync.sv
`timescale 1ns/1ps
module synth_cfg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/synth_cfg_shifter.sv
`timescale 1ns/1ps
module synth_cfg_shifter #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/synth_cfg_ctrl.sv
`timescale 1ns/1ps
module synth_cfg_ctrl
    import synth_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic le_s,
    output logic shift_en,
    output logic commit
);

    ld_state_e state, state_nx;
    logic      sclk_prev;
    logic      sclk_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SHIFT;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SHIFT:  if (le_s)  state_nx = ST_COMMIT;
            ST_COMMIT:            state_nx = ST_HOLD;
            ST_HOLD:   if (!le_s) state_nx = ST_SHIFT;
            default:              state_nx = ST_SHIFT;
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_SHIFT:  shift_en = sclk_rise & ~le_s;
            ST_COMMIT: commit   = 1'b1;
            ST_HOLD:   shift_en = 1'b0;
            default:   commit   = 1'b0;
        endcase
    end

endmodule

// File: rtl/synth_cfg_bank.sv
`timescale 1ns/1ps
module synth_cfg_bank
    import synth_cfg_pkg::*;
#(
    parameter int MIN_REF  = 3,
    parameter int MIN_MAIN = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [FRAME_W-1:0]            word,
    output ref_regs_t  [NUM_CH-1:0]       ref_q,
    output main_regs_t [NUM_CH-1:0]       main_q,
    output logic                          frame_err
);

    localparam logic [REF_W-1:0]  MIN_REF_V  = REF_W'(MIN_REF);
    localparam logic [MAIN_W-1:0] MIN_MAIN_V = MAIN_W'(MIN_MAIN);

    localparam ref_regs_t REF_RST = '{cp_hi: 1'b0, ratio: MIN_REF_V, tsel: '0};
    localparam main_regs_t MAIN_RST = '{count: MIN_MAIN_V, swallow: '0,
                                        pol: 1'b0, presc: 1'b0, mon: 1'b0};

    dest_e             dest;
    ref_regs_t         ref_cand;
    main_regs_t        main_cand;
    logic              legal;
    logic [NUM_CH-1:0] we_ref;
    logic [NUM_CH-1:0] we_main;

    assign dest      = dest_e'(word[1:0]);
    assign ref_cand  = ref_regs_t'(word[CS_POS:TSEL_LSB]);
    assign main_cand = main_regs_t'(word[FRAME_W-1:LDS_POS]);

    always_comb begin
        we_ref  = '0;
        we_main = '0;
        legal   = 1'b0;
        unique case (dest)
            DST_REF1: begin
                legal     = ref_cand.ratio >= MIN_REF_V;
                we_ref[0] = commit & legal;
            end
            DST_REF2: begin
                legal     = ref_cand.ratio >= MIN_REF_V;
                we_ref[1] = commit & legal;
            end
            DST_MAIN1: begin
                legal      = main_cand.count >= MIN_MAIN_V;
                we_main[0] = commit & legal;
            end
            DST_MAIN2: begin
                legal      = main_cand.count >= MIN_MAIN_V;
                we_main[1] = commit & legal;
            end
            default: legal = 1'b0;
        endcase
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            ref_regs_t  ref_r;
            main_regs_t main_r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ref_r <= REF_RST;
                end else if (we_ref[c]) begin
                    ref_r <= ref_cand;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    main_r <= MAIN_RST;
                end else if (we_main[c]) begin
                    main_r <= main_cand;
                end
            end

            assign ref_q[c]  = ref_r;
            assign main_q[c] = main_r;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
        end else if (commit && !legal) begin
            frame_err <= 1'b1;
        end
    end

endmodule

// File: rtl/synth_cfg_loader.sv
`timescale 1ns/1ps
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_REF     = 3,
    parameter int MIN_MAIN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio_ch1,
    output logic [TSEL_W-1:0] ref_tsel_ch1,
    output logic              cp_hi_ch1,
    output logic [MAIN_W-1:0] main_count_ch1,
    output logic [SWAL_W-1:0] swallow_ch1,
    output logic              presc_sel_ch1,
    output logic              phase_pol_ch1,
    output logic              mon_sel_ch1,
    output logic [REF_W-1:0]  ref_ratio_ch2,
    output logic [TSEL_W-1:0] ref_tsel_ch2,
    output logic              cp_hi_ch2,
    output logic [MAIN_W-1:0] main_count_ch2,
    output logic [SWAL_W-1:0] swallow_ch2,
    output logic              presc_sel_ch2,
    output logic              phase_pol_ch2,
    output logic              mon_sel_ch2,
    output logic              frame_err
);

    logic [2:0]               pins_s;
    logic                     shift_en;
    logic                     commit;
    logic [FRAME_W-1:0]       word;
    ref_regs_t  [NUM_CH-1:0]  ref_q;
    main_regs_t [NUM_CH-1:0]  main_q;

    synth_cfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_le, ser_data, ser_clk}),
        .q     (pins_s)
    );

    synth_cfg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[0]),
        .le_s     (pins_s[2]),
        .shift_en (shift_en),
        .commit   (commit)
    );

    synth_cfg_shifter #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (pins_s[1]),
        .word     (word)
    );

    synth_cfg_bank #(.MIN_REF(MIN_REF), .MIN_MAIN(MIN_MAIN)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .word      (word),
        .ref_q     (ref_q),
        .main_q    (main_q),
        .frame_err (frame_err)
    );

    assign ref_ratio_ch1  = ref_q[0].ratio;
    assign ref_tsel_ch1   = ref_q[0].tsel;
    assign cp_hi_ch1      = ref_q[0].cp_hi;
    assign main_count_ch1 = main_q[0].count;
    assign swallow_ch1    = main_q[0].swallow;
    assign presc_sel_ch1  = main_q[0].presc;
    assign phase_pol_ch1  = main_q[0].pol;
    assign mon_sel_ch1    = main_q[0].mon;

    assign ref_ratio_ch2  = ref_q[1].ratio;
    assign ref_tsel_ch2   = ref_q[1].tsel;
    assign cp_hi_ch2      = ref_q[1].cp_hi;
    assign main_count_ch2 = main_q[1].count;
    assign swallow_ch2    = main_q[1].swallow;
    assign presc_sel_ch2  = main_q[1].presc;
    assign phase_pol_ch2  = main_q[1].pol;
    assign mon_sel_ch2    = main_q[1].mon;

endmodule

// File: rtl/synth_cfg_loader_chk.sv
`timescale 1ns/1ps
module synth_cfg_loader_chk
    import synth_cfg_pkg::*;
#(
    parameter int MIN_REF  = 3,
    parameter int MIN_MAIN = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    commit,
    input ref_regs_t  [NUM_CH-1:0] ref_q,
    input main_regs_t [NUM_CH-1:0] main_q,
    input logic                    frame_err
);

    localparam logic [REF_W-1:0]  MIN_REF_V  = REF_W'(MIN_REF);
    localparam logic [MAIN_W-1:0] MIN_MAIN_V = MAIN_W'(MIN_MAIN);

    p_ref_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q[0].ratio >= MIN_REF_V) && (ref_q[1].ratio >= MIN_REF_V));

    p_main_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (main_q[0].count >= MIN_MAIN_V) && (main_q[1].count >= MIN_MAIN_V));

    p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    p_commit_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    p_hold_between_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ref_q) && $stable(main_q)));

endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(
    .MIN_REF  (MIN_REF),
    .MIN_MAIN (MIN_MAIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .ref_q     (ref_q),
    .main_q    (main_q),
    .frame_err (frame_err)
);

// File: tb/synth_cfg_loader_test.sv
`timescale 1ns/1ps
module synth_cfg_loader_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;

    logic [13:0] ref_ratio_ch1, ref_ratio_ch2;
    logic [1:0]  ref_tsel_ch1, ref_tsel_ch2;
    logic        cp_hi_ch1, cp_hi_ch2;
    logic [10:0] main_count_ch1, main_count_ch2;
    logic [6:0]  swallow_ch1, swallow_ch2;
    logic        presc_sel_ch1, presc_sel_ch2;
    logic        phase_pol_ch1, phase_pol_ch2;
    logic        mon_sel_ch1, mon_sel_ch2;
    logic        frame_err;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    synth_cfg_loader uut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_ratio_ch1(ref_ratio_ch1), .ref_tsel_ch1(ref_tsel_ch1), .cp_hi_ch1(cp_hi_ch1),
        .main_count_ch1(main_count_ch1), .swallow_ch1(swallow_ch1),
        .presc_sel_ch1(presc_sel_ch1), .phase_pol_ch1(phase_pol_ch1), .mon_sel_ch1(mon_sel_ch1),
        .ref_ratio_ch2(ref_ratio_ch2), .ref_tsel_ch2(ref_tsel_ch2), .cp_hi_ch2(cp_hi_ch2),
        .main_count_ch2(main_count_ch2), .swallow_ch2(swallow_ch2),
        .presc_sel_ch2(presc_sel_ch2), .phase_pol_ch2(phase_pol_ch2), .mon_sel_ch2(mon_sel_ch2),
        .frame_err(frame_err)
    );

    // frame bits: [1:0] destination, ref {dc4,cs,ratio14,t2,t1}, main {n11,a7,fc,sw,lds}
    localparam int NV = 9;
    localparam logic [23:0] VEC [NV] = '{
        {4'hF, 1'b1, 14'd100,   2'b01, 2'b00,       1'b1},
        {4'h0, 1'b0, 14'd16383, 2'b10, 2'b01,       1'b1},
        {11'd2047, 7'd127, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1},
        {11'd3, 7'd0, 1'b1, 1'b1, 1'b0, 2'b11,      1'b1},
        {4'h5, 1'b0, 14'd3,     2'b11, 2'b00,       1'b1},
        {4'h0, 1'b1, 14'd2,     2'b00, 2'b01,       1'b0},
        {11'd2, 7'd5, 1'b1, 1'b1, 1'b1, 2'b10,      1'b0},
        {4'h0, 1'b0, 14'd0,     2'b00, 2'b00,       1'b0},
        {11'd500, 7'd64, 1'b0, 1'b1, 1'b1, 2'b11,   1'b1}
    };

    logic [16:0] exp_ref [2];
    logic [20:0] exp_main [2];
    logic        exp_err;

    function automatic logic [16:0] act_ref(input int c);
        if (c == 0) return {cp_hi_ch1, ref_ratio_ch1, ref_tsel_ch1};
        return {cp_hi_ch2, ref_ratio_ch2, ref_tsel_ch2};
    endfunction

    function automatic logic [20:0] act_main(input int c);
        if (c == 0) return {main_count_ch1, swallow_ch1, phase_pol_ch1, presc_sel_ch1, mon_sel_ch1};
        return {main_count_ch2, swallow_ch2, phase_pol_ch2, presc_sel_ch2, mon_sel_ch2};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " ref ch1 R3 R4 R6"},  32'(act_ref(0)),  32'(exp_ref[0]));
        check({tag, " ref ch2 R3 R4 R6"},  32'(act_ref(1)),  32'(exp_ref[1]));
        check({tag, " main ch1 R2 R5 R6"}, 32'(act_main(0)), 32'(exp_main[0]));
        check({tag, " main ch2 R2 R5 R6"}, 32'(act_main(1)), 32'(exp_main[1]));
        check({tag, " frame_err R8 R10"},  32'(frame_err),   32'(exp_err));
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [22:0] f, input int nbits);
        for (int b = nbits - 1; b >= 0; b--) send_bit(f[b]);
    endtask

    task automatic load_pulse();
        @(negedge clk) ser_le = 1'b1;
        repeat (8) @(negedge clk);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic model(input logic [22:0] f, input logic ok);
        if (!ok) exp_err = 1'b1;
        else if (f[1] == 1'b0) exp_ref[f[0]] = f[18:2];
        else exp_main[f[0]] = f[22:2];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        exp_ref[0]  = {1'b0, 14'd3, 2'b00};
        exp_ref[1]  = {1'b0, 14'd3, 2'b00};
        exp_main[0] = {11'd3, 7'd0, 3'b000};
        exp_main[1] = {11'd3, 7'd0, 3'b000};
        exp_err     = 1'b0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("reset R1");

        // table walk: R2..R6, R8, R9, R10
        for (int i = 0; i < NV; i++) begin
            send_bits(VEC[i][23:1], 23);
            load_pulse();
            model(VEC[i][23:1], VEC[i][0]);
            check_all($sformatf("vec%0d R9", i));
        end

        // R11: latency of the load
        begin
            logic [22:0] f;
            f = {11'd77, 7'd33, 1'b0, 1'b1, 1'b0, 2'b10};
            send_bits(f, 23);
            @(negedge clk) ser_le = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R11 not yet at edge 3", 32'(act_main(0)), 32'(exp_main[0]));
            @(posedge clk);
            @(negedge clk);
            model(f, 1'b1);
            check("R11 visible at edge 4", 32'(act_main(0)), 32'(exp_main[0]));
            repeat (6) @(negedge clk);
            ser_le = 1'b0;
            repeat (6) @(negedge clk);
            check_all("R11 after pulse");
        end

        // R7: serial clock edges while the strobe is high shift nothing
        begin
            logic [22:0] fa;
            logic [22:0] fb;
            fa = {4'h0, 1'b0, 14'd50, 2'b00, 2'b00};
            fb = {11'd5, 7'd9, 3'b000, 2'b10};
            send_bits(fa, 23);
            @(negedge clk) ser_le = 1'b1;
            repeat (8) @(negedge clk);
            send_bit(1'b1);
            send_bit(1'b1);
            ser_le = 1'b0;
            repeat (6) @(negedge clk);
            model(fa, 1'b1);
            send_bits(fb, 22);
            load_pulse();
            model(fb, 1'b1);
            check("R7 main ch1 after high-strobe clocks", 32'(act_main(0)), 32'(exp_main[0]));
            check("R7 ref ch1", 32'(act_ref(0)), 32'(exp_ref[0]));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule